// File: doc/BRIEF.md
# Bitmap-Driven Packet Header Editor

This block sits after the forwarding lookup on a streaming packet path. Every packet arrives with a 64-bit metadata beat in front of its Ethernet frame. That metadata carries a 16-bit edit bitmap, and the lookup supplies an output port alongside it. The block reads the bitmap once per packet. It then rewrites the frame as the beats stream through: the destination and source MAC addresses, a decrement of the IPv4 TTL with an incremental header-checksum fix-up, or a decrement of the IPv6 hop limit. It drops the metadata beat, so the output queue sees only the frame.

A single decrement unit serves both IP versions. A small wrapper places it on byte 22 (IPv4 TTL) or byte 21 (IPv6 hop limit), depending on the bitmap. A packet whose counter is already 0 or 1 when a decrement is requested is left untouched and flagged for the CPU queue. Three custom-module enable bits are passed on as one-cycle strobes. Frame bytes travel big-endian, with byte 0 in the top lane of a beat. The metadata bitmap occupies bits 31:16 of the metadata word, which is the top 64 bits of the first beat.

Top module: `hdr_postproc`

## Requirements
- R1: The metadata beat (input beat with sop) is never forwarded. Each later input beat appears on the output one clock after it is accepted. The first frame beat carries out_sop, the beat with in_eop carries out_eop, and all bytes not named below pass unchanged.
- R2: Bitmap bit 3 clear rewrites frame bytes 0..5 with the next-hop MAC of the packet's output port (MAC bit 47 in byte 0). Bit 3 set leaves them unchanged.
- R3: Bitmap bit 0 clear rewrites frame bytes 6..11 with the MAC of the packet's output port. Bit 0 set leaves them unchanged.
- R4: With bit 4 clear and bit 1 clear, frame byte 22 (IPv4 TTL) is decremented by one. Bit 1 set leaves it unchanged.
- R5: When the TTL is decremented and bit 2 is clear, the checksum in bytes 24..25 is adjusted so that the IPv4 header (bytes 14..33) stays valid. With bit 2 set, the checksum bytes are left unchanged.
- R6: Bit 4 set decrements frame byte 21 (IPv6 hop limit) and takes precedence over bit 1. Byte 22 and the checksum bytes are then left unchanged.
- R7: If a requested decrement finds the counter at 0 or 1, the counter and the checksum are left unchanged and out_to_cpu is high on the out_eop beat. out_to_cpu is low on every other beat, and for packets with no such case.
- R8: out_cust[2:0] equals bitmap bits 7:5 on the out_sop beat (bit 5 drives custom module 1) and is zero on all other cycles.
- R9: A bitmap with bits 3:0 set and bits 7:4 clear yields a frame identical to the input.
- R10: While reset is high and after it, until a packet is sent, out_valid is low and out_cust is zero.
- R11: out_oport equals the in_oport value captured with the metadata beat, on every output beat of that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | Input beat is the metadata beat |
| in_eop | input | 1 | Input beat is the last of the packet |
| in_data | input | DATA_W | Input beat, byte 0 in the top lane |
| in_oport | input | PORT_W | Output port from lookup, sampled with in_sop |
| cfg_port_mac | input | NPORTS*48 | Per-port source MAC, port p at bits 48p+47:48p |
| cfg_nhop_mac | input | NPORTS*48 | Per-port next-hop MAC, same packing |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | First frame beat |
| out_eop | output | 1 | Last frame beat |
| out_data | output | DATA_W | Edited frame beat |
| out_oport | output | PORT_W | Output port of the current packet |
| out_to_cpu | output | 1 | Redirect to CPU queue, valid on out_eop beat |
| out_cust | output | 3 | Custom-module enable strobes, on out_sop beat |

## Verification
The hardest situations to reach are the interactions at the decrement. One is an expired counter that must suppress both the decrement and the checksum fix-up while still raising the redirect on a later beat. The other is a bitmap that asks for both the TTL and the hop-limit edit at once. The stimulus builds full 64-byte IPv4 and IPv6 frames with a valid header checksum, and sets the counter to 64, 1 or 0 under chosen bitmaps. The result is then judged by recomputing the whole IPv4 header checksum from the output bytes, not by repeating the incremental formula.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  // metadata word layout (top 64 bits of the first beat)
  localparam int META_W = 64;
  localparam int BM_LSB = 16;
  localparam int BM_W   = 16;

  // bitmap bit meanings
  localparam int BM_KEEP_SRC  = 0;
  localparam int BM_KEEP_TTL  = 1;
  localparam int BM_KEEP_CSUM = 2;
  localparam int BM_KEEP_DST  = 3;
  localparam int BM_HOP6      = 4;
  localparam int BM_CUST_LSB  = 5;
  localparam int N_CUST       = 3;

  // frame byte offsets used by the editors
  localparam int OFF_DST   = 0;
  localparam int OFF_SRC   = 6;
  localparam int MAC_BYTES = 6;
  localparam int OFF_HOP   = 21;
  localparam int OFF_TTL   = 22;
  localparam int OFF_CSUM  = 24;

  typedef struct packed {
    logic              keep_src;
    logic              keep_dst;
    logic              keep_csum;
    logic              dec_en;
    logic              use_hop;
    logic [N_CUST-1:0] cust;
  } pkt_ctl_t;

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [7:0] mac_byte(input logic [47:0] m, input logic [2:0] idx);
    logic [7:0] r;
    case (idx)
      3'd0:    r = m[47:40];
      3'd1:    r = m[39:32];
      3'd2:    r = m[31:24];
      3'd3:    r = m[23:16];
      3'd4:    r = m[15:8];
      3'd5:    r = m[7:0];
      default: r = 8'h00;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/hpp_ctx.sv
module hpp_ctx
  import hpp_pkg::*;
#(
  parameter int PORT_W = 2,
  parameter int BEAT_W = 3,
  parameter int SAT    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [BM_W-1:0]   bitmap,
  input  logic [PORT_W-1:0] in_oport,
  output logic              pkt_beat,
  output logic [BEAT_W-1:0] pbeat,
  output pkt_ctl_t          ctl,
  output logic [PORT_W-1:0] oport
);
  logic     in_pkt_q;
  pkt_ctl_t ctl_d;

  always_comb begin
    ctl_d.keep_src  = bitmap[BM_KEEP_SRC];
    ctl_d.keep_dst  = bitmap[BM_KEEP_DST];
    ctl_d.keep_csum = bitmap[BM_KEEP_CSUM];
    ctl_d.dec_en    = ~bitmap[BM_KEEP_TTL];
    ctl_d.use_hop   = bitmap[BM_HOP6];
    ctl_d.cust      = bitmap[BM_CUST_LSB +: N_CUST];
  end

  assign pkt_beat = in_valid & ~in_sop & in_pkt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt_q <= 1'b0;
      pbeat    <= '0;
      ctl      <= '0;
      oport    <= '0;
    end else if (in_valid && in_sop) begin
      in_pkt_q <= ~in_eop;
      pbeat    <= '0;
      ctl      <= ctl_d;
      oport    <= in_oport;
    end else if (pkt_beat) begin
      if (in_eop) in_pkt_q <= 1'b0;
      if (int'(pbeat) != SAT) pbeat <= pbeat + 1'b1;
    end
  end
endmodule

// File: rtl/hpp_dec_unit.sv
module hpp_dec_unit #(
  parameter int VAL_W = 8
) (
  input  logic [VAL_W-1:0] cur,
  output logic [VAL_W-1:0] nxt,
  output logic             expired
);
  assign nxt     = cur - 1'b1;
  assign expired = (cur <= VAL_W'(1));
endmodule

// File: rtl/hpp_dec_wrap.sv
module hpp_dec_wrap
  import hpp_pkg::*;
#(
  parameter int BYTES  = 8,
  parameter int BEAT_W = 3
) (
  input  logic              beat_ok,
  input  logic [BEAT_W-1:0] pbeat,
  input  logic              dec_en,
  input  logic              use_hop,
  input  logic [7:0]        byte_hop,
  input  logic [7:0]        byte_ttl,
  output logic              hit,
  output logic              expd,
  output logic [7:0]        new_val,
  output logic [7:0]        tgt_off
);
  localparam int HOP_BEAT = OFF_HOP / BYTES;
  localparam int TTL_BEAT = OFF_TTL / BYTES;

  logic       active;
  logic       exp_w;
  logic [7:0] src_val;

  always_comb begin
    if (use_hop) begin
      src_val = byte_hop;
      tgt_off = 8'(OFF_HOP);
      active  = beat_ok && (int'(pbeat) == HOP_BEAT);
    end else begin
      src_val = byte_ttl;
      tgt_off = 8'(OFF_TTL);
      active  = beat_ok && dec_en && (int'(pbeat) == TTL_BEAT);
    end
  end

  hpp_dec_unit #(.VAL_W(8)) u_dec (
    .cur     (src_val),
    .nxt     (new_val),
    .expired (exp_w)
  );

  assign hit  = active & ~exp_w;
  assign expd = active & exp_w;
endmodule

// File: rtl/hpp_csum_adj.sv
module hpp_csum_adj
  import hpp_pkg::*;
#(
  parameter logic [15:0] DELTA = 16'h0100
) (
  input  logic [15:0] old_sum,
  output logic [15:0] new_sum
);
  // a field lowered by DELTA raises the stored complement sum by DELTA
  assign new_sum = oc_add(old_sum, DELTA);
endmodule

// File: rtl/hdr_postproc.sv
module hdr_postproc
  import hpp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NPORTS = 4,
  parameter int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sop,
  input  logic                 in_eop,
  input  logic [DATA_W-1:0]    in_data,
  input  logic [PORT_W-1:0]    in_oport,
  input  logic [NPORTS*48-1:0] cfg_port_mac,
  input  logic [NPORTS*48-1:0] cfg_nhop_mac,
  output logic                 out_valid,
  output logic                 out_sop,
  output logic                 out_eop,
  output logic [DATA_W-1:0]    out_data,
  output logic [PORT_W-1:0]    out_oport,
  output logic                 out_to_cpu,
  output logic [2:0]           out_cust
);
  localparam int BYTES      = DATA_W / 8;
  localparam int SAT        = (OFF_CSUM + 2 + BYTES - 1) / BYTES;
  localparam int BEAT_W     = $clog2(SAT + 1);
  localparam int CSUM_BEAT  = OFF_CSUM / BYTES;
  localparam int CSUM_LANE  = OFF_CSUM % BYTES;
  localparam int HOP_LANE   = OFF_HOP % BYTES;
  localparam int TTL_LANE   = OFF_TTL % BYTES;

  logic              pkt_beat;
  logic [BEAT_W-1:0] pbeat;
  pkt_ctl_t          ctl;
  logic [PORT_W-1:0] oport;
  logic [BM_W-1:0]   bitmap;

  assign bitmap = in_data[DATA_W-META_W+BM_LSB +: BM_W];

  hpp_ctx #(.PORT_W(PORT_W), .BEAT_W(BEAT_W), .SAT(SAT)) u_ctx (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_eop   (in_eop),
    .bitmap   (bitmap),
    .in_oport (in_oport),
    .pkt_beat (pkt_beat),
    .pbeat    (pbeat),
    .ctl      (ctl),
    .oport    (oport)
  );

  // decrement path shared between TTL and hop limit
  logic       dec_hit, dec_expd;
  logic [7:0] dec_val, dec_off;

  hpp_dec_wrap #(.BYTES(BYTES), .BEAT_W(BEAT_W)) u_wrap (
    .beat_ok  (pkt_beat),
    .pbeat    (pbeat),
    .dec_en   (ctl.dec_en),
    .use_hop  (ctl.use_hop),
    .byte_hop (in_data[DATA_W-1-8*HOP_LANE -: 8]),
    .byte_ttl (in_data[DATA_W-1-8*TTL_LANE -: 8]),
    .hit      (dec_hit),
    .expd     (dec_expd),
    .new_val  (dec_val),
    .tgt_off  (dec_off)
  );

  // per-packet decrement history
  logic dec_done_q, exp_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_done_q <= 1'b0;
      exp_seen_q <= 1'b0;
    end else if (in_valid && in_sop) begin
      dec_done_q <= 1'b0;
      exp_seen_q <= 1'b0;
    end else begin
      if (dec_hit)  dec_done_q <= 1'b1;
      if (dec_expd) exp_seen_q <= 1'b1;
    end
  end

  // checksum fix-up
  logic [15:0] csum_old, csum_new;
  logic        csum_now;

  assign csum_old = in_data[DATA_W-1-8*CSUM_LANE -: 16];

  hpp_csum_adj #(.DELTA(16'h0100)) u_csum (
    .old_sum (csum_old),
    .new_sum (csum_new)
  );

  assign csum_now = pkt_beat && (int'(pbeat) == CSUM_BEAT) && !ctl.use_hop &&
                    !ctl.keep_csum && (dec_done_q || dec_hit);

  // MAC values for this packet's port
  logic [47:0] src_mac, dst_mac;
  assign src_mac = cfg_port_mac[oport*48 +: 48];
  assign dst_mac = cfg_nhop_mac[oport*48 +: 48];

  // byte-lane editors
  logic [DATA_W-1:0] edited;

  for (genvar l = 0; l < BYTES; l++) begin : g_lane
    int         pos;
    logic [7:0] b_in, b_out;

    assign b_in = in_data[DATA_W-1-8*l -: 8];

    always_comb begin
      pos   = int'(pbeat) * BYTES + l;
      b_out = b_in;
      if (!ctl.keep_dst && pos < OFF_DST + MAC_BYTES)
        b_out = mac_byte(dst_mac, 3'(pos - OFF_DST));
      if (!ctl.keep_src && pos >= OFF_SRC && pos < OFF_SRC + MAC_BYTES)
        b_out = mac_byte(src_mac, 3'(pos - OFF_SRC));
      if (dec_hit && pos == int'(dec_off))
        b_out = dec_val;
      if (csum_now && pos == OFF_CSUM)
        b_out = csum_new[15:8];
      if (csum_now && pos == OFF_CSUM + 1)
        b_out = csum_new[7:0];
    end

    assign edited[DATA_W-1-8*l -: 8] = b_out;
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sop    <= 1'b0;
      out_eop    <= 1'b0;
      out_data   <= '0;
      out_oport  <= '0;
      out_to_cpu <= 1'b0;
      out_cust   <= '0;
    end else begin
      out_valid  <= pkt_beat;
      out_sop    <= pkt_beat && (pbeat == '0);
      out_eop    <= pkt_beat && in_eop;
      out_to_cpu <= pkt_beat && in_eop && (exp_seen_q || dec_expd);
      out_cust   <= (pkt_beat && (pbeat == '0)) ? ctl.cust : '0;
      if (pkt_beat) begin
        out_data  <= edited;
        out_oport <= oport;
      end
    end
  end
endmodule

// File: rtl/hdr_postproc_chk.sv
module hdr_postproc_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_sop,
  input logic       out_valid,
  input logic       out_sop,
  input logic       out_eop,
  input logic       out_to_cpu,
  input logic [2:0] out_cust
);
  // R1: a metadata beat never produces an output beat
  p_meta_dropped_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop) |=> !out_valid);

  // R1: every output beat stems from an input beat one cycle earlier
  p_out_from_in_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R1: sop and eop markers only accompany a valid beat
  p_marks_valid_r1: assert property (@(posedge clk) disable iff (rst)
    (out_sop || out_eop) |-> out_valid);

  // R7: CPU redirect only on the final beat
  p_cpu_on_eop_r7: assert property (@(posedge clk) disable iff (rst)
    out_to_cpu |-> (out_valid && out_eop));

  // R8: custom strobes only on the first beat
  p_cust_on_sop_r8: assert property (@(posedge clk) disable iff (rst)
    (out_cust != 3'b000) |-> (out_valid && out_sop));
endmodule

bind hdr_postproc hdr_postproc_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_sop     (in_sop),
  .out_valid  (out_valid),
  .out_sop    (out_sop),
  .out_eop    (out_eop),
  .out_to_cpu (out_to_cpu),
  .out_cust   (out_cust)
);

// File: tb/hdr_postproc_tb.sv
module hdr_postproc_tb_top;
  localparam int DATA_W = 64;
  localparam int NPORTS = 4;
  localparam int PORT_W = 2;
  localparam int NB     = 64;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [DATA_W-1:0]    in_data = '0;
  logic [PORT_W-1:0]    in_oport = '0;
  logic [NPORTS*48-1:0] cfg_port_mac, cfg_nhop_mac;
  logic                 out_valid, out_sop, out_eop, out_to_cpu;
  logic [DATA_W-1:0]    out_data;
  logic [PORT_W-1:0]    out_oport;
  logic [2:0]           out_cust;

  always #2 clk = ~clk;

  hdr_postproc #(.DATA_W(DATA_W), .NPORTS(NPORTS)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .in_oport(in_oport), .cfg_port_mac(cfg_port_mac),
    .cfg_nhop_mac(cfg_nhop_mac), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_data(out_data), .out_oport(out_oport),
    .out_to_cpu(out_to_cpu), .out_cust(out_cust)
  );

  function automatic logic [47:0] pmac(input int p);
    return 48'h02_00_5E_00_10_00 + 48'(p);
  endfunction
  function automatic logic [47:0] nmac(input int p);
    return 48'h0A_BB_CC_DD_00_00 + 48'(p * 17);
  endfunction

  initial begin
    for (int p = 0; p < NPORTS; p++) begin
      cfg_port_mac[p*48 +: 48] = pmac(p);
      cfg_nhop_mac[p*48 +: 48] = nmac(p);
    end
  end

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // stimulus and expectations
  logic [7:0] pkt [0:NB-1];
  logic [7:0] exp [0:NB-1];
  bit         exp_cpu;

  // monitor
  logic [7:0] got [0:NB-1];
  int         got_n, sop_pos, eop_cnt, oport_bad, cust_stray, cpu_stray;
  bit         cpu_at_eop;
  logic [2:0] cust_seen;

  task automatic mon_clear();
    got_n = 0; sop_pos = -1; eop_cnt = 0; oport_bad = 0;
    cust_stray = 0; cpu_stray = 0; cpu_at_eop = 0; cust_seen = 3'b000;
  endtask

  int cur_oport;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (out_sop && sop_pos < 0) sop_pos = got_n;
        if (out_sop) cust_seen = out_cust;
        if (int'(out_oport) != cur_oport) oport_bad++;
        for (int b = 0; b < DATA_W/8; b++)
          if (got_n * 8 + b < NB) got[got_n*8 + b] = out_data[DATA_W-1-8*b -: 8];
        if (out_eop) begin eop_cnt++; cpu_at_eop = out_to_cpu; end
        got_n++;
      end
      if (out_cust != 3'b000 && !(out_valid && out_sop)) cust_stray++;
      if (out_to_cpu && !(out_valid && out_eop)) cpu_stray++;
    end
  end

  function automatic logic [15:0] hdr_csum(input bit use_exp);
    logic [31:0] s = 0;
    for (int i = 14; i < 34; i += 2) begin
      if (i == 24) continue;
      s += use_exp ? {exp[i], exp[i+1]} : {pkt[i], pkt[i+1]};
    end
    while (s[31:16] != 0) s = s[15:0] + s[31:16];
    return ~s[15:0];
  endfunction

  function automatic bit hdr_ok_out();
    logic [31:0] s = 0;
    for (int i = 14; i < 34; i += 2) s += {got[i], got[i+1]};
    while (s[31:16] != 0) s = s[15:0] + s[31:16];
    return s[15:0] == 16'hFFFF;
  endfunction

  task automatic build_v4(input logic [7:0] ttl);
    logic [15:0] c;
    for (int i = 0; i < NB; i++) pkt[i] = 8'(i * 7 + 3);
    pkt[12] = 8'h08; pkt[13] = 8'h00; pkt[14] = 8'h45; pkt[15] = 8'h00;
    pkt[16] = 8'h00; pkt[17] = 8'h32; pkt[22] = ttl; pkt[23] = 8'h11;
    pkt[24] = 8'h00; pkt[25] = 8'h00;
    c = hdr_csum(1'b0);
    pkt[24] = c[15:8]; pkt[25] = c[7:0];
  endtask

  task automatic build_v6(input logic [7:0] hop);
    for (int i = 0; i < NB; i++) pkt[i] = 8'(i * 5 + 1);
    pkt[12] = 8'h86; pkt[13] = 8'hDD; pkt[14] = 8'h60; pkt[20] = 8'h3A; pkt[21] = hop;
  endtask

  task automatic make_exp(input logic [15:0] bm, input int op, input int nb);
    logic [15:0] c;
    for (int i = 0; i < NB; i++) exp[i] = pkt[i];
    exp_cpu = 1'b0;
    if (!bm[3]) for (int i = 0; i < 6; i++) exp[i]   = nmac(op)[47-8*i -: 8];
    if (!bm[0]) for (int i = 0; i < 6; i++) exp[6+i] = pmac(op)[47-8*i -: 8];
    if (bm[4]) begin
      if (nb > 21) begin
        if (pkt[21] <= 1) exp_cpu = 1'b1; else exp[21] = pkt[21] - 1;
      end
    end else if (!bm[1] && nb > 22) begin
      if (pkt[22] <= 1) exp_cpu = 1'b1;
      else begin
        exp[22] = pkt[22] - 1;
        if (!bm[2] && nb >= 34) begin
          c = hdr_csum(1'b1);
          exp[24] = c[15:8]; exp[25] = c[7:0];
        end
      end
    end
  endtask

  task automatic send(input logic [15:0] bm, input int op, input int nb);
    mon_clear();
    cur_oport = op;
    @(negedge clk);
    in_valid <= 1'b1; in_sop <= 1'b1; in_eop <= 1'b0; in_oport <= PORT_W'(op);
    in_data <= {32'hC0FF_EE01, bm, 8'h02, 8'h05};
    for (int b = 0; b < nb / 8; b++) begin
      @(negedge clk);
      in_sop <= 1'b0; in_eop <= (b == nb / 8 - 1); in_oport <= PORT_W'(op ^ 1);
      for (int k = 0; k < 8; k++) in_data[63-8*k -: 8] <= pkt[b*8 + k];
    end
    @(negedge clk);
    in_valid <= 1'b0; in_eop <= 1'b0; in_data <= '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_pkt(input string req, input logic [15:0] bm, input int nb);
    int bad = -1;
    for (int i = nb - 1; i >= 0; i--) if (got[i] !== exp[i]) bad = i;
    chk(got_n == nb / 8 && sop_pos == 0 && eop_cnt == 1, {req, "/R1 framing"},
        64'(got_n), 64'(nb / 8));
    if (bad >= 0) chk(1'b0, {req, " bytes"}, {32'(bad), 24'd0, got[bad]}, {32'(bad), 24'd0, exp[bad]});
    else          chk(1'b1, {req, " bytes"}, 0, 0);
    chk(oport_bad == 0, "R11 oport", 64'(oport_bad), 0);
    chk(cpu_at_eop == exp_cpu && cpu_stray == 0, {req, "/R7 cpu"}, 64'(cpu_at_eop), 64'(exp_cpu));
    chk(cust_seen == bm[7:5] && cust_stray == 0, {req, "/R8 cust"}, 64'(cust_seen), 64'(bm[7:5]));
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0 && out_cust == 3'b000, "R10 reset", {out_valid, out_cust}, 0);
  endtask

  task automatic t_full_v4();  // R2 R3 R4 R5
    build_v4(8'd64); make_exp(16'h0000, 2, NB); send(16'h0000, 2, NB);
    check_pkt("R4 full v4", 16'h0000, NB);
    chk(hdr_ok_out(), "R5 header checksum valid", {got[24], got[25]}, {exp[24], exp[25]});
  endtask

  task automatic t_keep_csum();  // R5 with bit 2 set
    build_v4(8'd9); make_exp(16'h0004, 3, NB); send(16'h0004, 3, NB);
    check_pkt("R5 stale csum", 16'h0004, NB);
  endtask

  task automatic t_keep_macs();  // R2 R3 unchanged
    build_v4(8'd30); make_exp(16'h000B, 1, NB); send(16'h000B, 1, NB);
    check_pkt("R2 R3 keep macs", 16'h000B, NB);
  endtask

  task automatic t_v6_hop();  // R6, bit 1 also clear
    build_v6(8'd100); make_exp(16'h0010, 0, NB); send(16'h0010, 0, NB);
    check_pkt("R6 hop limit", 16'h0010, NB);
  endtask

  task automatic t_expired();  // R7
    build_v4(8'd1); make_exp(16'h0000, 2, NB); send(16'h0000, 2, NB);
    check_pkt("R7 ttl one", 16'h0000, NB);
    build_v6(8'd0); make_exp(16'h0010, 3, NB); send(16'h0010, 3, NB);
    check_pkt("R7 hop zero", 16'h0010, NB);
  endtask

  task automatic t_custom();  // R8
    build_v4(8'd20); make_exp(16'h00EF, 1, NB); send(16'h00EF, 1, NB);
    check_pkt("R8 all strobes", 16'h00EF, NB);
    build_v4(8'd20); make_exp(16'h004F, 0, NB); send(16'h004F, 0, NB);
    check_pkt("R8 module 2", 16'h004F, NB);
  endtask

  task automatic t_passthru();  // R9
    build_v4(8'd2); make_exp(16'h000F, 2, NB); send(16'h000F, 2, NB);
    check_pkt("R9 passthrough", 16'h000F, NB);
    chk(got[22] == pkt[22] && got[0] == pkt[0], "R9 untouched", {got[0], got[22]}, {pkt[0], pkt[22]});
  endtask

  task automatic t_short();  // R1 two-beat frame, edits only on MACs
    build_v4(8'd1); make_exp(16'h0000, 3, 16); send(16'h0000, 3, 16);
    check_pkt("R1 short", 16'h0000, 16);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst <= 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_full_v4();
    t_keep_csum();
    t_keep_macs();
    t_v6_hop();
    t_expired();
    t_custom();
    t_passthru();
    t_short();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule